// File: doc/BRIEF.md
# Paired GPIO Port Register File

This block holds the register state for two general-purpose I/O ports of up to eight lines each. Software reaches them through a small register bus. Each bus access can target the low port, the high port, or both at once as a single 16-bit paired port. The lane is chosen only by the byte enables, so the byte view and the 16-bit view share the same storage and cannot fall out of step. In the paired view, the lower-numbered port is the low byte and the next port is the high byte.

Every line has two stored bits: a direction bit and an output data bit. The direction bit drives the pin output enable directly. The pin inputs pass through a two-stage synchronizer, and the result is readable as a separate input register that software cannot write. A parameter for each port sets how many lines are implemented. Bits above that count hold no storage: they ignore writes, read as zero and never drive the pad.

Reads are registered. The read data for an address appears one clock after that address is presented. Pull resistors, drive strength and interrupt detection are handled elsewhere.

Top module: `gpio_pair_regs`

## Requirements
- R1: After reset, the output register and the direction register read as zero, and every pin output and output enable is 0, so every line starts as an input.
- R2: Each pin output enable follows its direction bit, and 1 selects output.
- R3: Each pin output follows its output data bit.
- R4: A write with both byte enables set (`be_i` = 2'b11) updates all 16 bits of the addressed register.
- R5: A write with only `be_i[0]` set updates bits 7:0 and leaves bits 15:8 of the addressed register unchanged.
- R6: A write with only `be_i[1]` set updates bits 15:8 and leaves bits 7:0 of the addressed register unchanged.
- R7: Bit positions at or above a port's implemented line count ignore writes, read back as 0 in every register, and drive 0 on both the pin output and the output enable.
- R8: A change on a pin input reaches the input register after two rising clock edges. A read presented in the same cycle as the change, or in the cycle after it, still returns the old value. A read presented in the cycle after that returns the new value.
- R9: `rdata_o` takes the value of the register addressed in a cycle at the next rising edge. Back-to-back reads of different addresses each return their own register.
- R10: Address encoding: 2'd0 selects the input register, 2'd1 the output register and 2'd2 the direction register. Writes to address 0 change no state.
- R11: Address 2'd3 is unmapped. It reads as zero, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register select (0 input, 1 output, 2 direction, 3 unmapped) |
| we_i | input | 1 | Write strobe |
| be_i | input | 2 | Byte lane enables (bit 0 is the low port, bit 1 is the high port) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| pin_in_i | input | 16 | Pad inputs, asynchronous |
| pin_out_o | output | 16 | Pad output values |
| pin_oe_o | output | 16 | Pad output enables (1 selects output) |

## Verification
The bench builds the block with eight lines on the low port and five on the high port. The full low lane tests complete byte-lane writes. The partial high lane makes bits 15:13 unimplemented, so the bench can check that those bits ignore writes, read as zero and never drive the pad. Mixed byte-enable writes on this uneven pair show that each lane keeps its neighbour's contents. Timed reads across a pin change measure the synchronizer delay exactly.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;
  localparam int LANE_W = 8;
  localparam int NUM_LANES = 2;
  localparam int PAIR_W = LANE_W * NUM_LANES;

  typedef enum logic [1:0] {
    REG_IN   = 2'd0,
    REG_OUT  = 2'd1,
    REG_DIR  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  function automatic logic [LANE_W-1:0] lane_mask(input int lines);
    logic [LANE_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANE_W; i++) begin
      if (i < lines) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_lane.sv
module gpio_lane
  import gpio_pair_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_out_i,
  input  logic              wr_dir_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] out_q_o,
  output logic [LANE_W-1:0] dir_q_o
);
  for (genvar b = 0; b < LANE_W; b++) begin : g_bit
    if (b < LINES) begin : g_impl
      logic out_q, dir_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          out_q <= 1'b0;
          dir_q <= 1'b0;
        end else begin
          if (wr_out_i) out_q <= wdata_i[b];
          if (wr_dir_i) dir_q <= wdata_i[b];
        end
      end
      assign out_q_o[b] = out_q;
      assign dir_q_o[b] = dir_q;
    end else begin : g_absent
      // no storage: writes dropped, reads zero
      assign out_q_o[b] = 1'b0;
      assign dir_q_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_pair_regs.sv
module gpio_pair_regs
  import gpio_pair_pkg::*;
#(
  parameter int NUM_LINES_LO = 8,
  parameter int NUM_LINES_HI = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  addr_i,
  input  logic        we_i,
  input  logic [1:0]  be_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  input  logic [15:0] pin_in_i,
  output logic [15:0] pin_out_o,
  output logic [15:0] pin_oe_o
);
  localparam logic [PAIR_W-1:0] PAIR_MASK =
    {lane_mask(NUM_LINES_HI), lane_mask(NUM_LINES_LO)};

  reg_sel_e          sel;
  logic [PAIR_W-1:0] out_q, dir_q, in_sync;
  logic [PAIR_W-1:0] rdata_d, rdata_q;

  assign sel = reg_sel_e'(addr_i);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    localparam int LN = (l == 0) ? NUM_LINES_LO : NUM_LINES_HI;
    logic wr_lane;
    assign wr_lane = we_i && be_i[l];

    gpio_lane #(.LINES(LN)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_out_i(wr_lane && (sel == REG_OUT)),
      .wr_dir_i(wr_lane && (sel == REG_DIR)),
      .wdata_i (wdata_i[l*LANE_W +: LANE_W]),
      .out_q_o (out_q[l*LANE_W +: LANE_W]),
      .dir_q_o (dir_q[l*LANE_W +: LANE_W])
    );
  end

  gpio_sync #(.W(PAIR_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_in_i),
    .q_o   (in_sync)
  );

  always_comb begin
    unique case (sel)
      REG_IN:  rdata_d = in_sync & PAIR_MASK;
      REG_OUT: rdata_d = out_q;
      REG_DIR: rdata_d = dir_q;
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o   = rdata_q;
  assign pin_out_o = out_q;
  assign pin_oe_o  = dir_q;

  a_r4_full_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && be_i == 2'b11 && addr_i == 2'd1) |=> pin_out_o == ($past(wdata_i) & PAIR_MASK));

  a_r5_low_keeps_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && be_i == 2'b01) |=> $stable(pin_out_o[15:8]) && $stable(pin_oe_o[15:8]));

  a_r6_high_keeps_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && be_i == 2'b10) |=> $stable(pin_out_o[7:0]) && $stable(pin_oe_o[7:0]));

  a_r7_unimpl_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_out_o | pin_oe_o | rdata_o) & ~PAIR_MASK) == '0);

  a_r9_read_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && addr_i == 2'd2) |=> rdata_o == $past(pin_oe_o));

  a_r10_in_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd0) |=> $stable(pin_out_o) && $stable(pin_oe_o));

  a_r11_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd3) |=> rdata_o == '0 && $stable(pin_out_o) && $stable(pin_oe_o));
endmodule

// File: tb/gpio_pair_regs_tb.sv
module gpio_pair_regs_tb;
  localparam int LO = 8;
  localparam int HI = 5;
  localparam logic [15:0] MASK = 16'h1FFF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [1:0]  be_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o, pin_in_i, pin_out_o, pin_oe_o;

  gpio_pair_regs #(.NUM_LINES_LO(LO), .NUM_LINES_HI(HI)) u_dut (
    .clk_i, .rst_ni, .addr_i, .we_i, .be_i, .wdata_i, .rdata_o,
    .pin_in_i, .pin_out_o, .pin_oe_o
  );

  always #2.5 clk_i = ~clk_i;

  typedef struct {
    logic [15:0] exp;
    int          due;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [15:0] m_out = '0, m_dir = '0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop queued read expectations as results appear
  always @(negedge clk_i) begin
    if (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      chk(it.tag, rdata_o, it.exp);
    end
  end

  task automatic rd(logic [1:0] a, logic [15:0] exp, string tag);
    @(negedge clk_i);
    addr_i = a;
    we_i   = 1'b0;
    q.push_back('{exp: exp, due: cyc + 1, tag: tag});
  endtask

  task automatic wr(logic [1:0] a, logic [1:0] be, logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; be_i = be; wdata_i = d; we_i = 1'b1;
    for (int i = 0; i < 2; i++) begin
      logic [7:0] lane = d[i*8 +: 8] & MASK[i*8 +: 8];
      if (be[i] && a == 2'd1) m_out[i*8 +: 8] = lane;
      if (be[i] && a == 2'd2) m_dir[i*8 +: 8] = lane;
    end
    @(negedge clk_i);
    we_i = 1'b0; be_i = '0;
  endtask

  task automatic pins(string tag);
    @(negedge clk_i);
    chk({tag, " pin_out"}, pin_out_o, m_out);
    chk({tag, " pin_oe"}, pin_oe_o, m_dir);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    pin_in_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    pins("R1");
    rd(2'd1, 16'h0000, "R1 out reg");
    rd(2'd2, 16'h0000, "R1 dir reg");
    drain();
    // R4 full-width write, R3 and R7 on high lane
    wr(2'd1, 2'b11, 16'hA5C3);
    pins("R3 R7");
    rd(2'd1, 16'h05C3, "R4 full write");
    // R5 low lane only
    wr(2'd1, 2'b01, 16'h0F3C);
    rd(2'd1, 16'h053C, "R5 low lane");
    // R6 high lane only
    wr(2'd1, 2'b10, 16'hFF00);
    rd(2'd1, 16'h1F3C, "R6 high lane");
    pins("R3 R6");
    // R2 direction drives output enable
    wr(2'd2, 2'b11, 16'hFFFF);
    pins("R2 R7");
    rd(2'd2, 16'h1FFF, "R7 dir unimpl");
    wr(2'd2, 2'b01, 16'h0000);
    pins("R2 R5");
    wr(2'd2, 2'b10, 16'h0A00);
    pins("R2 R6");
    // R10 write to input register inert
    wr(2'd0, 2'b11, 16'hFFFF);
    pins("R10");
    rd(2'd0, 16'h0000, "R10 in reg");
    // R11 unmapped
    wr(2'd3, 2'b11, 16'hFFFF);
    pins("R11");
    rd(2'd3, 16'h0000, "R11 unmapped read");
    // R9 back-to-back reads of distinct addresses
    rd(2'd1, 16'h1F3C, "R9 read out");
    rd(2'd2, 16'h0A00, "R9 read dir");
    rd(2'd3, 16'h0000, "R9 read none");
    rd(2'd1, 16'h1F3C, "R9 read out again");
    drain();
    // R8 synchronizer latency
    @(negedge clk_i);
    pin_in_i = 16'hFFFF;
    addr_i = 2'd0;
    q.push_back('{exp: 16'h0000, due: cyc + 1, tag: "R8 same cycle"});
    rd(2'd0, 16'h0000, "R8 one cycle");
    rd(2'd0, 16'h1FFF, "R8 two cycles R7");
    rd(2'd0, 16'h1FFF, "R8 steady");
    @(negedge clk_i);
    pin_in_i = 16'h1234;
    drain();
    rd(2'd0, 16'h1234, "R8 new pattern");
    drain();
    // reset mid-run returns to R1 state
    rst_ni = 1'b0;
    m_out = '0; m_dir = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    pins("R1 re-reset");
    rd(2'd2, 16'h0000, "R1 dir after re-reset");
    drain();
    if (q.size() != 0) chk("queue drained", 16'(q.size()), 16'h0000);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule